// File: doc/BRIEF.md
# Accumulator Instruction Decoder

This block is the decode stage of a small 8-bit single-accumulator processor. It takes the instruction stream one byte at a time over a valid/ready handshake. For each instruction it produces a registered record of decoded fields:

- a one-hot operation class,
- a register index,
- a sub-operation code,
- the post-increment amount and data-segment select for memory operations,
- the immediate byte,
- a length flag,
- separate exception flags for the trap opcode and for reserved encodings.

Any first byte whose upper nibble is all ones is followed by an immediate byte. The decoder keeps the first byte internally until the second byte arrives. Only then does it present the complete record. The output record stays stable until the consumer takes it with `dec_ready`. While the record is waiting, no new byte is accepted. Executing the operation, the register file and the memory are left to the stages behind this one.

Top module: `acc_insn_decoder`

## Requirements
- R1: While `dec_valid` is high, exactly one bit of `dec_class` is set. The bit positions are:
  - 0 trap, 1 no-op, 2 print, 3 call absolute via accumulator, 4 call relative via accumulator, 5 single-operand ALU,
  - 6 special-register read, 7 special-register write, 8 register read, 9 register write, 10 swap, 11 less-than compare, 12 register ALU,
  - 13 load, 14 store, 15 logic immediate, 16 add immediate, 17 bit operation, 18 branch-if-zero, 19 relative jump,
  - 20 absolute call immediate, 21 relative call immediate, 22 load immediate, 23 extension escape, 24 reserved.
- R2: First bytes 0x00 through 0x0F decode as follows:
  - 0x00 gives trap, 0x01 gives no-op and 0x02 gives print.
  - 0x06 gives call absolute via accumulator, and 0x07 gives call relative via accumulator.
  - 0x08 through 0x0F give single-operand ALU with `dec_sub` equal to byte bits [2:0].
  - 0x03 through 0x05 are reserved.
- R3: A byte 0001_wsss decodes as a special-register read (w=0) or write (w=1), with `dec_sub` equal to sss. The special index sss must be 0, 1 or 2; any other index makes the byte reserved.
- R4: Register forms place byte bits [2:0] on `dec_reg`:
  - 0010_0rrr is register read and 0010_1rrr is register write.
  - 0011_0rrr is swap and 0011_1rrr is less-than compare.
  - 01ooorrr is register ALU with `dec_sub` equal to ooo.
- R5: A byte 10 g i s rrr (bit 5 g, bit 4 i, bit 3 s) is a store when s=1 and a load when s=0. `dec_inc` equals i, `dec_seg2` equals g, and `dec_reg` equals rrr.
- R6: Bytes 110x_xxxx and 1110_xxxx are reserved one-byte encodings.
- R7: A first byte 1111_xxxx gives `dec_two`=1 and `dec_imm` equal to the second byte, whatever the encoding. Every other instruction gives `dec_two`=0 and `dec_imm`=0.
- R8: Within the 1111_nnnn group:
  - n=0..2 is logic immediate with `dec_sub`=n.
  - n=4 is branch-if-zero, 5 is relative jump, 6 is absolute call and 7 is relative call.
  - n=14 is load immediate and n=15 is extension escape.
  - n=8..13 are reserved.
- R9: First byte 0xF3 splits on the second byte m:
  - m[7]=0 gives add immediate with `dec_sub`=0.
  - m[7:6]=10 gives bit operation with `dec_sub`=m[5:3] and `dec_reg`=m[2:0].
  - m[7:6]=11 gives add immediate with `dec_sub`=1.
- R10: `dec_trap` is 1 only for class trap, and `dec_illegal` is 1 exactly for class reserved. The two flags are never high together. For trap and reserved records, `dec_reg`, `dec_sub`, `dec_inc` and `dec_seg2` are 0.
- R11: `in_ready` is low while a record is held with `dec_ready` low. A one-byte instruction accepted at a clock edge appears with `dec_valid` high after that edge.
- R12: After the first byte of a two-byte instruction is accepted, `dec_valid` stays low until the second byte is accepted. The record appears after the edge that accepts the second byte.
- R13: While `dec_valid` is high and `dec_ready` is low, every output field holds its value.
- R14: Reset (`rst_n` low) clears `dec_valid` and discards a half-collected two-byte instruction. The next byte is then taken as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| dec_valid | output | 1 | Decoded record present |
| dec_ready | input | 1 | Consumer takes the record |
| dec_class | output | 25 | One-hot operation class |
| dec_reg | output | 3 | Register index or bit index |
| dec_sub | output | 3 | Sub-operation / special-register index |
| dec_inc | output | 1 | Post-increment amount for load/store |
| dec_seg2 | output | 1 | Second data segment selected |
| dec_imm | output | 8 | Immediate byte (0 for one-byte forms) |
| dec_two | output | 1 | Instruction was two bytes long |
| dec_illegal | output | 1 | Reserved encoding |
| dec_trap | output | 1 | Trap opcode |

## Verification
The bench walks every one-byte opcode and every 1111_nnnn opcode. For 0xF3 it uses second bytes at the 0x7F/0x80, 0xBF/0xC0 and 0xFF boundaries. A decoder with a shifted field or a misread prefix would report the wrong class or sub-op, for example treating 0xC0 as a bit operation or 0x80 as an add. Reserved opcodes inside the immediate group (0xF8–0xFD) are fed with their second byte. A decoder that treated them as one byte long would misalign the rest of the stream and fail every later record. Random consumer stalls catch a register that updates or drops its record while it is held. A reset applied between the two bytes of a long instruction catches a decoder that keeps its half-collected state and misreads the next opcode as an immediate.

// File: rtl/acc_dec_pkg.sv
package acc_dec_pkg;
  localparam int BYTE_W    = 8;
  localparam int NIB_W     = 4;
  localparam int IDX_W     = 3;
  localparam int NUM_CLS   = 25;
  localparam int CLS_IDX_W = $clog2(NUM_CLS);
  localparam logic [NIB_W-1:0] LONG_NIB = '1;

  typedef enum logic [CLS_IDX_W-1:0] {
    CL_TRAP      = 5'd0,  CL_NOP       = 5'd1,  CL_PRINT    = 5'd2,
    CL_CALL_AABS = 5'd3,  CL_CALL_AREL = 5'd4,  CL_ALU1     = 5'd5,
    CL_SPEC_GET  = 5'd6,  CL_SPEC_PUT  = 5'd7,  CL_REG_GET  = 5'd8,
    CL_REG_SET   = 5'd9,  CL_SWAP      = 5'd10, CL_LESS     = 5'd11,
    CL_ALU_REG   = 5'd12, CL_LOAD      = 5'd13, CL_STORE    = 5'd14,
    CL_LOGIC_IMM = 5'd15, CL_ADD_IMM   = 5'd16, CL_BIT_IMM  = 5'd17,
    CL_BRZ       = 5'd18, CL_JMP_REL   = 5'd19, CL_CALL_IABS = 5'd20,
    CL_CALL_IREL = 5'd21, CL_LOAD_IMM  = 5'd22, CL_EXTEND   = 5'd23,
    CL_RSVD      = 5'd24
  } op_cls_e;

  typedef struct packed {
    op_cls_e           cls;
    logic [IDX_W-1:0]  reg_idx;
    logic [IDX_W-1:0]  sub;
    logic              inc;
    logic              seg2;
    logic [BYTE_W-1:0] imm;
    logic              two;
  } dec_fields_t;

  function automatic logic is_long(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: NIB_W] == LONG_NIB;
  endfunction

  // Decode of a complete one-byte instruction.
  function automatic dec_fields_t decode_short(input logic [BYTE_W-1:0] b);
    dec_fields_t f;
    f = '0;
    f.cls = CL_RSVD;
    casez (b)
      8'b0000_0000: f.cls = CL_TRAP;
      8'b0000_0001: f.cls = CL_NOP;
      8'b0000_0010: f.cls = CL_PRINT;
      8'b0000_0110: f.cls = CL_CALL_AABS;
      8'b0000_0111: f.cls = CL_CALL_AREL;
      8'b0000_1???: begin f.cls = CL_ALU1; f.sub = b[2:0]; end
      8'b0001_????: begin
        if (b[2:0] <= 3'd2) begin
          f.cls = b[3] ? CL_SPEC_PUT : CL_SPEC_GET;
          f.sub = b[2:0];
        end
      end
      8'b0010_0???: begin f.cls = CL_REG_GET; f.reg_idx = b[2:0]; end
      8'b0010_1???: begin f.cls = CL_REG_SET; f.reg_idx = b[2:0]; end
      8'b0011_0???: begin f.cls = CL_SWAP;    f.reg_idx = b[2:0]; end
      8'b0011_1???: begin f.cls = CL_LESS;    f.reg_idx = b[2:0]; end
      8'b01??_????: begin
        f.cls = CL_ALU_REG; f.sub = b[5:3]; f.reg_idx = b[2:0];
      end
      8'b10??_????: begin
        f.cls     = b[3] ? CL_STORE : CL_LOAD;
        f.inc     = b[4];
        f.seg2    = b[5];
        f.reg_idx = b[2:0];
      end
      default: f.cls = CL_RSVD;
    endcase
    return f;
  endfunction

  // Decode of the immediate group: op is the low nibble of byte 0.
  function automatic dec_fields_t decode_long(input logic [NIB_W-1:0] op,
                                              input logic [BYTE_W-1:0] m);
    dec_fields_t f;
    f = '0;
    f.two = 1'b1;
    f.imm = m;
    f.cls = CL_RSVD;
    case (op)
      4'h0, 4'h1, 4'h2: begin f.cls = CL_LOGIC_IMM; f.sub = {1'b0, op[1:0]}; end
      4'h3: begin
        if (m[7] && !m[6]) begin
          f.cls = CL_BIT_IMM; f.sub = m[5:3]; f.reg_idx = m[2:0];
        end else begin
          f.cls = CL_ADD_IMM; f.sub = {2'b00, m[7]};
        end
      end
      4'h4: f.cls = CL_BRZ;
      4'h5: f.cls = CL_JMP_REL;
      4'h6: f.cls = CL_CALL_IABS;
      4'h7: f.cls = CL_CALL_IREL;
      4'hE: f.cls = CL_LOAD_IMM;
      4'hF: f.cls = CL_EXTEND;
      default: f.cls = CL_RSVD;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/acc_dec_fetch.sv
module acc_dec_fetch
  import acc_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              slot_free,
  output logic              in_ready,
  output logic              waiting,
  output logic [BYTE_W-1:0] first_b,
  output logic [BYTE_W-1:0] second_b,
  output logic              use_long,
  output logic              ev_take_first,
  output logic              ev_take_long,
  output logic              ev_take_imm,
  output logic              ev_emit
);
  logic              accept;
  logic [BYTE_W-1:0] held_q;

  assign in_ready      = slot_free;
  assign accept        = in_valid && in_ready;
  assign ev_take_first = accept && !waiting;
  assign ev_take_long  = ev_take_first && is_long(in_byte);
  assign ev_take_imm   = accept && waiting;
  assign ev_emit       = (ev_take_first && !is_long(in_byte)) || ev_take_imm;

  assign use_long = waiting;
  assign first_b  = waiting ? held_q : in_byte;
  assign second_b = waiting ? in_byte : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      held_q  <= '0;
    end else begin
      if (ev_take_long) begin
        waiting <= 1'b1;
        held_q  <= in_byte;
      end else if (ev_take_imm) begin
        waiting <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acc_dec_select.sv
module acc_dec_select
  import acc_dec_pkg::*;
(
  input  logic               [BYTE_W-1:0] first_b,
  input  logic               [BYTE_W-1:0] second_b,
  input  logic                            use_long,
  output dec_fields_t                     fields,
  output logic              [NUM_CLS-1:0] cls_onehot,
  output logic                            illegal,
  output logic                            trap
);
  dec_fields_t f_short;
  dec_fields_t f_long;

  always_comb begin
    f_short = decode_short(first_b);
    f_long  = decode_long(first_b[NIB_W-1:0], second_b);
    fields  = use_long ? f_long : f_short;
  end

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    assign cls_onehot[k] = (fields.cls == CLS_IDX_W'(k));
  end

  assign illegal = (fields.cls == CL_RSVD);
  assign trap    = (fields.cls == CL_TRAP);
endmodule

// File: rtl/acc_dec_outreg.sv
module acc_dec_outreg
  import acc_dec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    dec_ready,
  input  dec_fields_t             d_fields,
  input  logic      [NUM_CLS-1:0] d_onehot,
  input  logic                    d_illegal,
  input  logic                    d_trap,
  output logic                    valid,
  output logic                    slot_free,
  output dec_fields_t             q_fields,
  output logic      [NUM_CLS-1:0] q_onehot,
  output logic                    q_illegal,
  output logic                    q_trap
);
  assign slot_free = !valid || dec_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      q_fields  <= '0;
      q_onehot  <= '0;
      q_illegal <= 1'b0;
      q_trap    <= 1'b0;
    end else begin
      if (load) begin
        valid     <= 1'b1;
        q_fields  <= d_fields;
        q_onehot  <= d_onehot;
        q_illegal <= d_illegal;
        q_trap    <= d_trap;
      end else if (dec_ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acc_insn_decoder.sv
module acc_insn_decoder
  import acc_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_byte,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic [NUM_CLS-1:0] dec_class,
  output logic [IDX_W-1:0]   dec_reg,
  output logic [IDX_W-1:0]   dec_sub,
  output logic               dec_inc,
  output logic               dec_seg2,
  output logic [BYTE_W-1:0]  dec_imm,
  output logic               dec_two,
  output logic               dec_illegal,
  output logic               dec_trap
);
  logic              slot_free;
  logic              waiting;
  logic [BYTE_W-1:0] first_b;
  logic [BYTE_W-1:0] second_b;
  logic              use_long;
  logic              ev_take_first;
  logic              ev_take_long;
  logic              ev_take_imm;
  logic              ev_emit;

  dec_fields_t        d_fields;
  dec_fields_t        q_fields;
  logic [NUM_CLS-1:0] d_onehot;
  logic               d_illegal;
  logic               d_trap;

  acc_dec_fetch u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_byte       (in_byte),
    .slot_free     (slot_free),
    .in_ready      (in_ready),
    .waiting       (waiting),
    .first_b       (first_b),
    .second_b      (second_b),
    .use_long      (use_long),
    .ev_take_first (ev_take_first),
    .ev_take_long  (ev_take_long),
    .ev_take_imm   (ev_take_imm),
    .ev_emit       (ev_emit)
  );

  acc_dec_select u_select (
    .first_b    (first_b),
    .second_b   (second_b),
    .use_long   (use_long),
    .fields     (d_fields),
    .cls_onehot (d_onehot),
    .illegal    (d_illegal),
    .trap       (d_trap)
  );

  acc_dec_outreg u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_emit),
    .dec_ready (dec_ready),
    .d_fields  (d_fields),
    .d_onehot  (d_onehot),
    .d_illegal (d_illegal),
    .d_trap    (d_trap),
    .valid     (dec_valid),
    .slot_free (slot_free),
    .q_fields  (q_fields),
    .q_onehot  (dec_class),
    .q_illegal (dec_illegal),
    .q_trap    (dec_trap)
  );

  assign dec_reg  = q_fields.reg_idx;
  assign dec_sub  = q_fields.sub;
  assign dec_inc  = q_fields.inc;
  assign dec_seg2 = q_fields.seg2;
  assign dec_imm  = q_fields.imm;
  assign dec_two  = q_fields.two;
endmodule

// File: rtl/acc_insn_decoder_chk.sv
module acc_insn_decoder_chk
  import acc_dec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               dec_valid,
  input logic               dec_ready,
  input logic [NUM_CLS-1:0] dec_class,
  input logic [IDX_W-1:0]   dec_reg,
  input logic [IDX_W-1:0]   dec_sub,
  input logic [BYTE_W-1:0]  dec_imm,
  input logic               dec_two,
  input logic               dec_illegal,
  input logic               dec_trap,
  input logic               waiting,
  input logic               ev_take_first,
  input logic               ev_take_long,
  input logic               ev_take_imm
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $countones(dec_class) == 1);

  p_short_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_two |-> dec_imm == '0);

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !(dec_trap && dec_illegal));

  p_rsvd_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_illegal == dec_class[CL_RSVD]);

  p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |-> !in_ready);

  p_short_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take_first && !ev_take_long |=> dec_valid && !dec_two);

  p_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take_long |=> !dec_valid && waiting);

  p_long_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take_imm |=> dec_valid && dec_two);

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_class) &&
      $stable(dec_reg) && $stable(dec_sub) && $stable(dec_imm));
endmodule

bind acc_insn_decoder acc_insn_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .dec_valid     (dec_valid),
  .dec_ready     (dec_ready),
  .dec_class     (dec_class),
  .dec_reg       (dec_reg),
  .dec_sub       (dec_sub),
  .dec_imm       (dec_imm),
  .dec_two       (dec_two),
  .dec_illegal   (dec_illegal),
  .dec_trap      (dec_trap),
  .waiting       (waiting),
  .ev_take_first (ev_take_first),
  .ev_take_long  (ev_take_long),
  .ev_take_imm   (ev_take_imm)
);

// File: tb/acc_insn_decoder_test.sv
module acc_insn_decoder_test;
  import acc_dec_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [7:0]         in_byte = '0;
  logic               dec_valid;
  logic               dec_ready = 1'b1;
  logic [NUM_CLS-1:0] dec_class;
  logic [2:0]         dec_reg, dec_sub;
  logic               dec_inc, dec_seg2, dec_two, dec_illegal, dec_trap;
  logic [7:0]         dec_imm;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  bit bp_on = 0;
  logic [7:0] lfsr = 8'hA5;

  typedef struct {
    int         cls;
    logic [2:0] rg, sb;
    logic       inc, seg2, two, ill, trp;
    logic [7:0] imm;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  acc_insn_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_class(dec_class), .dec_reg(dec_reg), .dec_sub(dec_sub),
    .dec_inc(dec_inc), .dec_seg2(dec_seg2), .dec_imm(dec_imm),
    .dec_two(dec_two), .dec_illegal(dec_illegal), .dec_trap(dec_trap)
  );

  function automatic exp_t model(input logic [7:0] a, input logic [7:0] m);
    exp_t e;
    logic [3:0] hi, lo;
    hi = a[7:4]; lo = a[3:0];
    e.cls = 24; e.rg = 0; e.sb = 0; e.inc = 0; e.seg2 = 0;
    e.two = 0; e.imm = 0; e.tag = "R2";
    if (hi == 4'hF) begin
      e.two = 1; e.imm = m; e.tag = "R8";
      if (lo <= 4'd2) begin e.cls = 15; e.sb = lo[2:0]; end
      else if (lo == 4'd3) begin
        e.tag = "R9";
        if (m[7:6] == 2'b10) begin e.cls = 17; e.sb = m[5:3]; e.rg = m[2:0]; end
        else begin e.cls = 16; e.sb = {2'b00, m[7]}; end
      end
      else if (lo >= 4'd4 && lo <= 4'd7) e.cls = 18 + int'(lo) - 4;
      else if (lo == 4'd14) e.cls = 22;
      else if (lo == 4'd15) e.cls = 23;
    end else if (hi == 4'h0) begin
      if (lo == 0) e.cls = 0;
      else if (lo == 1) e.cls = 1;
      else if (lo == 2) e.cls = 2;
      else if (lo == 6) e.cls = 3;
      else if (lo == 7) e.cls = 4;
      else if (lo >= 8) begin e.cls = 5; e.sb = lo[2:0]; end
    end else if (hi == 4'h1) begin
      e.tag = "R3";
      if (lo[2:0] < 3'd3) begin e.cls = lo[3] ? 7 : 6; e.sb = lo[2:0]; end
    end else if (hi == 4'h2 || hi == 4'h3) begin
      e.tag = "R4"; e.cls = 8 + int'({hi[0], lo[3]}); e.rg = lo[2:0];
    end else if (hi >= 4'h4 && hi <= 4'h7) begin
      e.tag = "R4"; e.cls = 12; e.sb = a[5:3]; e.rg = a[2:0];
    end else if (hi >= 4'h8 && hi <= 4'hB) begin
      e.tag = "R5"; e.cls = a[3] ? 14 : 13; e.inc = a[4]; e.seg2 = a[5]; e.rg = a[2:0];
    end else begin
      e.tag = "R6";
    end
    e.ill = (e.cls == 24);
    e.trp = (e.cls == 0);
    return e;
  endfunction

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic drive_byte(input logic [7:0] b);
    bit done;
    done = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!done) begin
      #2;
      done = in_ready;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] m, input int gap);
    exp_t e;
    e = model(a, m);
    sb_q.push_back(e);
    drive_byte(a);
    if (e.two) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        #3;
        check(dec_valid == 1'b0,
              $sformatf("R12 valid before immediate: act %0b exp 0", dec_valid));
      end
      drive_byte(m);
    end
  endtask

  // Monitor and scoreboard.
  logic               hold_pend = 0;
  logic [NUM_CLS-1:0] h_cls;
  logic [7:0]         h_imm;
  logic [2:0]         h_reg, h_sub;

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      dec_ready = bp_on ? lfsr[0] : 1'b1;
      #2;
      if (!rst_n) begin
        hold_pend = 0;
      end else begin
        if (hold_pend) begin
          check(dec_valid && dec_class == h_cls && dec_imm == h_imm &&
                dec_reg == h_reg && dec_sub == h_sub,
                $sformatf("R13 hold: act v%0b cls %h imm %h exp v1 cls %h imm %h",
                          dec_valid, dec_class, dec_imm, h_cls, h_imm));
        end
        if (dec_valid && !dec_ready) begin
          check(!in_ready, $sformatf("R11 in_ready while blocked: act %0b exp 0", in_ready));
          hold_pend = 1; h_cls = dec_class; h_imm = dec_imm; h_reg = dec_reg; h_sub = dec_sub;
        end else begin
          hold_pend = 0;
        end
        if (dec_valid && dec_ready) begin
          if (sb_q.size() == 0) begin
            check(0, "R11 record with nothing expected");
          end else begin
            exp_t e;
            logic [NUM_CLS-1:0] ec;
            e  = sb_q.pop_front();
            ec = {{(NUM_CLS-1){1'b0}}, 1'b1} << e.cls;
            check(dec_class == ec && dec_reg == e.rg && dec_sub == e.sb &&
                  dec_inc == e.inc && dec_seg2 == e.seg2 && dec_imm == e.imm &&
                  dec_two == e.two && dec_illegal == e.ill && dec_trap == e.trp,
                  $sformatf("%s R1 R7 R10 record: act cls %h reg %0d sub %0d inc %0b seg2 %0b imm %h two %0b ill %0b trp %0b / exp cls %h reg %0d sub %0d inc %0b seg2 %0b imm %h two %0b ill %0b trp %0b",
                            e.tag, dec_class, dec_reg, dec_sub, dec_inc, dec_seg2, dec_imm,
                            dec_two, dec_illegal, dec_trap, ec, e.rg, e.sb, e.inc, e.seg2,
                            e.imm, e.two, e.ill, e.trp));
          end
        end
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired: act running exp finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check(dec_valid == 0 && in_ready == 1,
          $sformatf("R14 reset state: act valid %0b ready %0b exp 0 1", dec_valid, in_ready));
    rst_n = 1'b1;

    // All one-byte opcodes, free-flowing consumer.
    for (int b = 0; b < 240; b++) send(8'(b), 8'h00, 0);
    // Immediate group with several second bytes.
    for (int n = 0; n < 16; n++) send(8'hF0 | 8'(n), 8'h5A, 1);
    send(8'hF3, 8'h00, 0); send(8'hF3, 8'h7F, 0); send(8'hF3, 8'h80, 2);
    send(8'hF3, 8'hBF, 0); send(8'hF3, 8'hC0, 0); send(8'hF3, 8'hFF, 1);
    send(8'hF3, 8'h95, 0); send(8'hF4, 8'h80, 0); send(8'hFE, 8'hFF, 0);
    send(8'hF9, 8'h01, 0); send(8'h01, 8'h00, 0);

    // Consumer stalls: R11 and R13.
    bp_on = 1;
    for (int b = 0; b < 240; b += 7) send(8'(b), 8'h00, 0);
    for (int n = 0; n < 16; n++) send(8'hF0 | 8'(n), 8'(8'h3C + n * 13), 0);
    send(8'hF3, 8'hC5, 0);
    send(8'hF3, 8'hA9, 1);
    while (sb_q.size() != 0) @(negedge clk);
    bp_on = 0;
    repeat (3) @(negedge clk);

    // R14: reset between the two bytes of a long instruction.
    drive_byte(8'hF4);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #3;
    check(dec_valid == 0, $sformatf("R14 valid in reset: act %0b exp 0", dec_valid));
    rst_n = 1'b1;
    send(8'h01, 8'h00, 0);
    send(8'h2B, 8'h00, 0);
    while (sb_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule